// File: doc/BRIEF.md
# Run-Length Sample Encoder

This block compresses a stream of wide logic samples into run-length records before they are uploaded to a host. Each record carries a sample value and a repeat counter. The counter holds the number of consecutive occurrences minus one. The encoder takes samples through a valid/ready input. A flush request on the same input closes the stream. Records leave as a byte stream with a valid/ready handshake, six bytes per record at the default widths.

Every counter value except the all-ones code describes real data. The all-ones code is kept for a single end-of-stream record that follows the last data record of a stream, so a data run is capped one step below that code. When the byte consumer stalls, the encoder holds back its input. It never drops samples and never merges them.

Top module: `rle_encoder`

## Requirements
- R1: After a synchronous reset, out_valid is low and in_ready is high at the first cycle after rst_n rises.
- R2: Each record leaves as 6 bytes. Bytes 0 to 3 hold the 32-bit sample value, least significant byte first. Bytes 4 and 5 hold the 16-bit counter, least significant byte first.
- R3: A counter of n means the value was accepted n+1 times in a row. A change of value closes the open run and emits its record.
- R4: A run closes as soon as its counter reaches 0xFFFE, which is 65535 samples. The next equal sample opens a new run at counter 0. A data record never carries counter 0xFFFF.
- R5: An accepted flush emits any open run first. It then emits one end record with value 0 and counter 0xFFFF. out_last is high only on byte 5 of that end record.
- R6: A flush with no open run emits only the end record.
- R7: A flush is taken in a cycle where in_ready is high. A sample accepted in that same cycle belongs to the stream being closed. in_ready stays low from the next cycle until the end record is queued, and in_valid has no effect while in_ready is low.
- R8: While out_valid is high and out_ready is low, out_byte and out_last hold their values. Under any stall pattern the record sequence is the same as with no stalls.
- R9: After the end record, a new stream starts with no open run. A first sample equal to the last value of the previous stream opens a fresh run at counter 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present on in_data |
| in_data | input | 32 | Sample value |
| in_flush | input | 1 | Request to close the stream; taken when in_ready is high |
| in_ready | output | 1 | Encoder can take a sample or flush this cycle |
| out_valid | output | 1 | out_byte holds a record byte |
| out_byte | output | 8 | Serialized record byte |
| out_last | output | 1 | Final byte of the end-of-stream record |
| out_ready | input | 1 | Consumer takes out_byte this cycle |

## Verification
The bench targets the counter boundary with a 65537-sample run of one value. A design that capped the run one step late would emit the reserved end code as data. A design that capped it one step early would split the run in the wrong place. The bench also flushes with a sample in the same cycle and with no open run. A design that got the ordering wrong would lose the final sample, emit an empty run record, or let a stray sample in during the flush. A randomly stalled byte consumer shows whether a backpressured design drops, duplicates or corrupts bytes. A stream restarted on the old value shows whether a run wrongly carries over across the end record.

// File: rtl/rle_pkg.sv
// Shared types for the run-length encoder.
// Assumes: nothing beyond the importing module's own parameters.
package rle_pkg;

    // Phases of the run tracker: taking samples, or closing a stream.
    typedef enum logic [1:0] {
        TRK_ACCEPT    = 2'd0,
        TRK_FLUSH_RUN = 2'd1,
        TRK_FLUSH_END = 2'd2
    } trk_state_t;

endpackage

// File: rtl/rle_run_tracker.sv
// Run tracker: folds equal consecutive samples into one open run, and
// issues {value, repeats-1} records through a one-entry output register.
// Assumes: CNT_W >= 2, so the cap code (all ones minus one) is nonzero.
module rle_run_tracker
    import rle_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_flush,
    output logic              smp_ready,
    output logic              rec_valid,
    output logic [DATA_W-1:0] rec_value,
    output logic [CNT_W-1:0]  rec_count,
    input  logic              rec_ready
);

    localparam logic [CNT_W-1:0] CNT_END = '1;
    localparam logic [CNT_W-1:0] CNT_CAP = CNT_END - CNT_W'(1);

    trk_state_t        state_q, state_d;
    logic              open_q, open_d;
    logic [DATA_W-1:0] val_q, val_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              out_v_q;
    logic [DATA_W-1:0] out_val_q;
    logic [CNT_W-1:0]  out_cnt_q;

    logic              slot_free;
    logic              take_smp;
    logic              take_flush;
    logic              emit;
    logic [DATA_W-1:0] emit_val;
    logic [CNT_W-1:0]  emit_cnt;

    // Output slot is usable when empty or being drained this cycle.
    always_comb begin
        slot_free  = !out_v_q || rec_ready;
        smp_ready  = (state_q == TRK_ACCEPT) && slot_free;
        take_smp   = smp_valid && smp_ready;
        take_flush = smp_flush && smp_ready;
    end

    // Next run state and the record to emit, if any.
    always_comb begin
        state_d  = state_q;
        open_d   = open_q;
        val_d    = val_q;
        cnt_d    = cnt_q;
        emit     = 1'b0;
        emit_val = val_q;
        emit_cnt = cnt_q;
        case (state_q)
            TRK_ACCEPT: begin
                if (take_smp) begin
                    if (open_q && smp_data == val_q) begin
                        if (cnt_q + CNT_W'(1) == CNT_CAP) begin
                            emit     = 1'b1;
                            emit_cnt = CNT_CAP;
                            open_d   = 1'b0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end else begin
                        emit   = open_q;
                        open_d = 1'b1;
                        val_d  = smp_data;
                        cnt_d  = '0;
                    end
                end
                if (take_flush) begin
                    state_d = TRK_FLUSH_RUN;
                end
            end
            TRK_FLUSH_RUN: begin
                if (slot_free) begin
                    if (open_q) begin
                        emit    = 1'b1;
                        open_d  = 1'b0;
                        state_d = TRK_FLUSH_END;
                    end else begin
                        emit     = 1'b1;
                        emit_val = '0;
                        emit_cnt = CNT_END;
                        state_d  = TRK_ACCEPT;
                    end
                end
            end
            TRK_FLUSH_END: begin
                if (slot_free) begin
                    emit     = 1'b1;
                    emit_val = '0;
                    emit_cnt = CNT_END;
                    state_d  = TRK_ACCEPT;
                end
            end
            default: state_d = TRK_ACCEPT;
        endcase
    end

    // Run registers and phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_ACCEPT;
            open_q  <= 1'b0;
            val_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            open_q  <= open_d;
            val_q   <= val_d;
            cnt_q   <= cnt_d;
        end
    end

    // One-entry record register toward the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v_q   <= 1'b0;
            out_val_q <= '0;
            out_cnt_q <= '0;
        end else if (emit) begin
            out_v_q   <= 1'b1;
            out_val_q <= emit_val;
            out_cnt_q <= emit_cnt;
        end else if (rec_ready) begin
            out_v_q <= 1'b0;
        end
    end

    assign rec_valid = out_v_q;
    assign rec_value = out_val_q;
    assign rec_count = out_cnt_q;

endmodule

// File: rtl/rle_rec_fifo.sv
// Record queue: small synchronous FIFO between the tracker and the
// serializer, so whole records are buffered while bytes drain.
// Assumes: DEPTH is a power of two and at least 2.
module rle_rec_fifo #(
    parameter int WIDTH = 48,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_valid,
    input  logic [WIDTH-1:0]           push_data,
    output logic                       push_ready,
    output logic                       pop_valid,
    output logic [WIDTH-1:0]           pop_data,
    input  logic                       pop_ready,
    output logic [$clog2(DEPTH):0]     level
);

    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      cnt_q;
    logic             do_push, do_pop;

    // Handshake decode.
    always_comb begin
        push_ready = (cnt_q != (AW+1)'(DEPTH));
        pop_valid  = (cnt_q != '0);
        do_push    = push_valid && push_ready;
        do_pop     = pop_valid && pop_ready;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
                2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign pop_data = mem[rd_ptr];
    assign level    = cnt_q;

endmodule

// File: rtl/rle_byte_ser.sv
// Byte serializer: sends one record as REC_W/8 bytes, least significant
// byte first, and flags the last byte of the end-of-stream record.
// Assumes: REC_W is a multiple of 8; the counter sits in the top CNT_W bits.
module rle_byte_ser #(
    parameter int REC_W = 48,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid,
    input  logic [REC_W-1:0] rec_data,
    output logic             rec_ready,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic             byte_last,
    input  logic             byte_ready
);

    localparam int NBYTES = REC_W / 8;
    localparam int IW     = $clog2(NBYTES);
    localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);

    logic             busy_q;
    logic [IW-1:0]    idx_q;
    logic [REC_W-1:0] hold_q;
    logic             end_q;
    logic [7:0]       lanes [NBYTES];
    logic             final_beat;

    // Split the held record into byte lanes.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = hold_q[8*g +: 8];
    end

    // Load a new record when idle or when the last byte leaves now.
    always_comb begin
        final_beat = busy_q && byte_ready && (idx_q == LAST_IDX);
        rec_ready  = !busy_q || final_beat;
    end

    // Byte position, held record and end-record flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            hold_q <= '0;
            end_q  <= 1'b0;
        end else if (rec_valid && rec_ready) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            hold_q <= rec_data;
            end_q  <= (rec_data[REC_W-1 -: CNT_W] == '1);
        end else if (busy_q && byte_ready) begin
            if (idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    assign byte_valid = busy_q;
    assign byte_data  = lanes[idx_q];
    assign byte_last  = busy_q && end_q && (idx_q == LAST_IDX);

endmodule

// File: rtl/rle_encoder.sv
// Run-length sample encoder top: tracker, record queue and byte
// serializer in a chain, each stage with valid/ready backpressure.
// Assumes: (DATA_W + CNT_W) is a multiple of 8, QUEUE_DEPTH a power of two.
module rle_encoder #(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 16,
    parameter int QUEUE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_flush,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              out_last,
    input  logic              out_ready
);

    localparam int REC_W = DATA_W + CNT_W;
    localparam int LVL_W = $clog2(QUEUE_DEPTH) + 1;

    logic              trk_valid;
    logic [DATA_W-1:0] trk_value;
    logic [CNT_W-1:0]  trk_count;
    logic              trk_ready;
    logic              q_valid;
    logic [REC_W-1:0]  q_data;
    logic              q_ready;
    logic [LVL_W-1:0]  q_level;

    rle_run_tracker #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (in_valid),
        .smp_data  (in_data),
        .smp_flush (in_flush),
        .smp_ready (in_ready),
        .rec_valid (trk_valid),
        .rec_value (trk_value),
        .rec_count (trk_count),
        .rec_ready (trk_ready)
    );

    rle_rec_fifo #(
        .WIDTH (REC_W),
        .DEPTH (QUEUE_DEPTH)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (trk_valid),
        .push_data  ({trk_count, trk_value}),
        .push_ready (trk_ready),
        .pop_valid  (q_valid),
        .pop_data   (q_data),
        .pop_ready  (q_ready),
        .level      (q_level)
    );

    rle_byte_ser #(
        .REC_W (REC_W),
        .CNT_W (CNT_W)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_valid  (q_valid),
        .rec_data   (q_data),
        .rec_ready  (q_ready),
        .byte_valid (out_valid),
        .byte_data  (out_byte),
        .byte_last  (out_last),
        .byte_ready (out_ready)
    );

endmodule

// File: rtl/rle_encoder_chk.sv
// Property checker for rle_encoder, attached by bind below.
// Assumes: connected to the top's ports and its inter-stage signals.
module rle_encoder_chk #(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 16,
    parameter int QUEUE_DEPTH = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              in_flush,
    input logic                              in_ready,
    input logic                              out_valid,
    input logic                              out_ready,
    input logic [7:0]                        out_byte,
    input logic                              out_last,
    input logic                              trk_valid,
    input logic [DATA_W-1:0]                 trk_value,
    input logic [CNT_W-1:0]                  trk_count,
    input logic [$clog2(QUEUE_DEPTH):0]      q_level
);

    localparam int NBYTES = (DATA_W + CNT_W) / 8;
    localparam int PW     = $clog2(NBYTES);
    localparam int LVL_W  = $clog2(QUEUE_DEPTH) + 1;

    logic [PW-1:0] pos_q;

    // Independent count of the byte position within a record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (out_valid && out_ready) begin
            pos_q <= (pos_q == PW'(NBYTES - 1)) ? '0 : pos_q + PW'(1);
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last)); // R8

    AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> pos_q == PW'(NBYTES - 1)); // R5

    AST_FLUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_flush && in_ready |=> !in_ready); // R7

    AST_END_CODE_ONLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        trk_valid && trk_count == '1 |-> trk_value == '0); // R4

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= LVL_W'(QUEUE_DEPTH)); // R8

endmodule

bind rle_encoder rle_encoder_chk #(
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .QUEUE_DEPTH (QUEUE_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_flush  (in_flush),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .trk_valid (trk_valid),
    .trk_value (trk_value),
    .trk_count (trk_count),
    .q_level   (q_level)
);

// File: tb/rle_encoder_test.sv
`timescale 1ns/1ps
module rle_encoder_test;

    localparam logic [15:0] END_CNT = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_flush = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_last;
    logic        out_ready = 1'b1;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [31:0] exp_val [0:255];
    logic [15:0] exp_cnt [0:255];
    string       exp_tag [0:255];
    int          nexp = 0;
    int          got = 0;

    logic        stall_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [47:0] cur_rec = '0;
    logic [5:0]  cur_last = '0;
    int          bpos = 0;

    rle_encoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_flush  (in_flush),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    always #2.5 clk = ~clk;

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles == 190000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Collector: set out_ready for the coming edge, then rebuild records.
    always @(negedge clk) begin
        if (stall_on) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = lfsr[0] | lfsr[5];
        end else begin
            out_ready = 1'b1;
        end
        if (rst_n && out_valid && out_ready) begin
            cur_rec[8*bpos +: 8] = out_byte;
            cur_last[bpos] = out_last;
            if (bpos == 5) begin
                bpos = 0;
                checks = checks + 1;
                if (got >= nexp) begin
                    errors = errors + 1;
                    $display("FAIL R3 extra record: actual %h/%h, expected none",
                             cur_rec[31:0], cur_rec[47:32]);
                end else begin
                    // R2: value bytes 0-3 then counter bytes 4-5, both LSB first
                    if (cur_rec[31:0] !== exp_val[got] || cur_rec[47:32] !== exp_cnt[got]) begin
                        errors = errors + 1;
                        $display("FAIL %s record %0d: actual %h/%h, expected %h/%h",
                                 exp_tag[got], got, cur_rec[31:0], cur_rec[47:32],
                                 exp_val[got], exp_cnt[got]);
                    end
                    checks = checks + 1;
                    if (cur_last !== {(exp_cnt[got] == END_CNT), 5'b0}) begin
                        errors = errors + 1;
                        $display("FAIL R5 last flags record %0d: actual %b, expected %b",
                                 got, cur_last, {(exp_cnt[got] == END_CNT), 5'b0});
                    end
                end
                got = got + 1;
            end else begin
                bpos = bpos + 1;
            end
        end
    end

    task automatic expect_rec(input logic [31:0] v, input logic [15:0] c, input string tag);
        exp_val[nexp] = v;
        exp_cnt[nexp] = c;
        exp_tag[nexp] = tag;
        nexp = nexp + 1;
    endtask

    // Present a sample (optionally with flush) until it is accepted.
    task automatic send(input logic [31:0] v, input logic fl);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        in_flush = fl;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic send_flush_only();
        @(negedge clk);
        in_valid = 1'b0;
        in_flush = 1'b1;
        while (!in_ready) @(negedge clk);
    endtask

    // Drop the inputs and wait for every expected record.
    task automatic finish_scenario(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        in_flush = 1'b0;
        for (int i = 0; i < 4000 && !(got == nexp && !out_valid); i++) @(negedge clk);
        for (int i = 0; i < 20; i++) @(negedge clk);
        checks = checks + 1;
        if (got != nexp) begin
            errors = errors + 1;
            $display("FAIL %s record count: actual %0d, expected %0d", tag, got, nexp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks = checks + 1;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors = errors + 1;
            $display("FAIL R1 reset: actual valid=%b ready=%b, expected valid=0 ready=1",
                     out_valid, in_ready);
        end
    endtask

    // R2 R3 R5: mixed runs then flush.
    task automatic t_basic();
        expect_rec(32'hA1B2C3D4, 16'd2, "R3");
        expect_rec(32'h00000000, 16'd0, "R2");
        expect_rec(32'h80000001, 16'd1, "R3");
        expect_rec(32'h0, END_CNT, "R5");
        send(32'hA1B2C3D4, 1'b0);
        send(32'hA1B2C3D4, 1'b0);
        send(32'hA1B2C3D4, 1'b0);
        send(32'h00000000, 1'b0);
        send(32'h80000001, 1'b0);
        send(32'h80000001, 1'b0);
        send_flush_only();
        finish_scenario("R5");
    endtask

    // R6: flush with nothing open.
    task automatic t_empty_flush();
        expect_rec(32'h0, END_CNT, "R6");
        send_flush_only();
        finish_scenario("R6");
    endtask

    // R7: sample with flush belongs to the closing stream; stray input ignored.
    task automatic t_flush_with_sample();
        expect_rec(32'h0000D00D, 16'd2, "R7");
        expect_rec(32'h0, END_CNT, "R7");
        send(32'h0000D00D, 1'b0);
        send(32'h0000D00D, 1'b0);
        send(32'h0000D00D, 1'b1);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'h0BAD0BAD;
        in_flush = 1'b0;
        checks = checks + 1;
        if (in_ready !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R7 in_ready after flush: actual %b, expected 0", in_ready);
        end
        finish_scenario("R7");
    endtask

    // R9: new stream on the same value starts a fresh run.
    task automatic t_restart();
        expect_rec(32'h0000D00D, 16'd0, "R9");
        expect_rec(32'h0, END_CNT, "R9");
        send(32'h0000D00D, 1'b1);
        finish_scenario("R9");
    endtask

    // R8: random output stalls must not change the record sequence.
    task automatic t_backpressure();
        stall_on = 1'b1;
        for (int k = 0; k < 10; k++) expect_rec(32'h1000 + k, 16'd2, "R8");
        expect_rec(32'h0, END_CNT, "R8");
        for (int i = 0; i < 30; i++) send(32'h1000 + i / 3, 1'b0);
        send_flush_only();
        finish_scenario("R8");
        stall_on = 1'b0;
    endtask

    // R4: run cap at 0xFFFE, then a fresh run of the same value.
    task automatic t_long_run();
        expect_rec(32'h00EEEE00, 16'hFFFE, "R4");
        expect_rec(32'h00EEEE00, 16'd1, "R4");
        expect_rec(32'h0000FFFF, 16'd0, "R4");
        expect_rec(32'h0, END_CNT, "R4");
        for (int i = 0; i < 65537; i++) send(32'h00EEEE00, 1'b0);
        send(32'h0000FFFF, 1'b1);
        finish_scenario("R4");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_empty_flush();
        t_flush_with_sample();
        t_restart();
        t_backpressure();
        t_long_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule